// File: doc/BRIEF.md
# Synchronous Burst SRAM with Wrapping Address Counter

This block is a clocked static memory of 18-bit words intended to hold cache line data. Every input except the output enable is captured at the rising clock edge. An access sequence opens when either of two active-low start strobes is low at an edge and the chip enable is low at that same edge. One strobe comes from the processor and the other from the cache controller. The external address is loaded at that edge. After that, an internal 2-bit counter steps the low address bits through the aligned block of four words, one step for each edge at which the active-low advance input is low.

Writes are committed internally from the captured values, so no external write pulse is needed. Each 18-bit word has two 9-bit lanes, and each lane has its own active-low write enable. A cycle started by the processor strobe is always a read. The shared data bus is presented as a pad driver pair: a data value and a drive enable. The drive enable is gated without a clock by the active-low output enable. The word depth is a parameter; the full device uses a 16-bit address, and the default is reduced for simulation.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected and `dq_en` is 0.
- R2: At an edge where `ts_cpu_n` or `ts_ctl_n` is low and `ce_n` is low, the block is selected and `addr` becomes the access address.
- R3: At an edge where a start strobe is low and `ce_n` is high, the block becomes deselected, and no read or write takes place until the next selecting start. `ce_n` is ignored at edges where neither start strobe is low.
- R4: At an edge with no start strobe low, while selected and with `adv_n` low, address bits [1:0] increment modulo 4. The upper bits are unchanged, so 1,2,3,0 wraps within the aligned four-word block.
- R5: At an edge with no start strobe and `adv_n` high, the access address and the selection are held.
- R6: When a start strobe and `adv_n` are both low at the same edge, the start reloads the address and the advance has no effect.
- R7: In a write cycle, `we_lo_n` low writes `dq_in[8:0]` and `we_hi_n` low writes `dq_in[17:9]`. Both low writes the whole word. A lane whose enable is high keeps its old value.
- R8: A cycle is a write only when the block is selected, at least one write enable is low and `ts_cpu_n` is high. An access opened with `ts_cpu_n` low is a read even if a write enable is low. A start with `ts_ctl_n` may be a write.
- R9: For a read cycle captured at edge k, `dq_out` carries the addressed word and `dq_en` is 1 (given `oe_n` low) from edge k+1 until edge k+2.
- R10: `dq_en` follows `oe_n` without waiting for a clock: it is 0 while `oe_n` is high. It is also 0 when the previous cycle was not a selected read.
- R11: During a write cycle `dq_en` is 0 whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| dq_in | input | 18 | Data arriving from the shared bus |
| ts_cpu_n | input | 1 | Processor start strobe, active low, forces a read |
| ts_ctl_n | input | 1 | Cache-controller start strobe, active low |
| adv_n | input | 1 | Burst address advance, active low |
| ce_n | input | 1 | Chip enable, active low, sampled only with a start |
| we_lo_n | input | 1 | Write enable for bits 8:0, active low |
| we_hi_n | input | 1 | Write enable for bits 17:9, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dq_out | output | 18 | Data driven toward the shared bus |
| dq_en | output | 1 | Bus drive enable (high = driving, low = high impedance) |

## Verification
The properties assume that every input is at a defined 0 or 1 level at each rising edge. The bench ensures this by changing inputs only at the falling edge. The properties also assume that `addr` lies inside the configured depth; the random stimulus masks it to that range. The bus data is never taken from the block's own output, so it is treated as free. The bench drives `dq_in` on every cycle, with random values, whether or not a write is intended.

// File: rtl/bsr_pkg.sv
// Shared constants and control bundle for the burst SRAM.
// Assumes an 18-bit word made of two 9-bit lanes.
package bsr_pkg;
    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    // Control inputs after polarity conversion (all active high).
    typedef struct packed {
        logic             start;      // either start strobe asserted
        logic             cpu_start;  // processor strobe asserted
        logic             ce;         // chip enable asserted
        logic             adv;        // advance asserted
        logic [LANES-1:0] we;         // lane write enables
    } bsr_ctrl_t;
endpackage

// File: rtl/bsr_addr_ctl.sv
// Selection state and access address register with a wrapping burst
// counter in the low bits. A start reloads the address (and wins over an
// advance); chip enable matters only at start edges.
// Assumes ctrl is a clean, registered-at-edge view of the pins.
module bsr_addr_ctl
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  bsr_ctrl_t         ctrl,
    output logic              sel_next,
    output logic              sel_q,
    output logic [ADDR_W-1:0] a_q
);
    // Selection that will hold after this edge.
    always_comb begin
        sel_next = ctrl.start ? ctrl.ce : sel_q;
    end

    // Load on selecting start, step low bits on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            a_q   <= '0;
        end else if (ctrl.start) begin
            sel_q <= ctrl.ce;
            if (ctrl.ce) begin
                a_q <= addr;
            end
        end else if (sel_q && ctrl.adv) begin
            a_q[BURST_W-1:0] <= a_q[BURST_W-1:0] + BURST_W'(1);
        end
    end
endmodule

// File: rtl/bsr_cycle_dec.sv
// Classifies each captured cycle as read, write or idle and registers the
// lane mask and incoming data. A processor-started cycle is never a write.
// Assumes sel_next reflects the selection for the cycle being captured.
module bsr_cycle_dec
    import bsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_next,
    input  bsr_ctrl_t         ctrl,
    input  logic [WORD_W-1:0] din,
    output logic              wr_q,
    output logic              rd_q,
    output logic [LANES-1:0]  lane_q,
    output logic [WORD_W-1:0] din_q
);
    logic wr_d;

    // Write needs selection, a lane enable and no processor start.
    always_comb begin
        wr_d = sel_next && (|ctrl.we) && !ctrl.cpu_start;
    end

    // Capture cycle kind, lane mask and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            lane_q <= '0;
            din_q  <= '0;
        end else begin
            wr_q   <= wr_d;
            rd_q   <= sel_next && !wr_d;
            lane_q <= ctrl.we;
            din_q  <= din;
        end
    end
endmodule

// File: rtl/bsr_array.sv
// Lane-split storage. A captured write commits at the following edge; a
// captured read loads the output register at the following edge.
// Assumes rd and wr are never both high. Storage is not reset.
module bsr_array
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [LANES-1:0]  lane,
    input  logic [ADDR_W-1:0] a,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] rdata_q,
    output logic              rv_q
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_lane;

        // Self-timed lane write from captured values.
        always_ff @(posedge clk) begin
            if (wr && lane[l]) begin
                mem[a] <= din[l*LANE_W +: LANE_W];
            end
        end

        // Registered lane read.
        always_ff @(posedge clk) begin
            if (rd) begin
                rd_lane <= mem[a];
            end
        end

        assign rdata_q[l*LANE_W +: LANE_W] = rd_lane;
    end

    // Marks the cycle in which read data is on the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
        end else begin
            rv_q <= rd;
        end
    end
endmodule

// File: rtl/burst_sram.sv
// Top of the synchronous burst SRAM. Converts pin polarity, instantiates
// address control, cycle decode and storage, and gates the bus drive with
// the asynchronous output enable.
// Assumes the pad ring combines dq_out/dq_en into a three-state bus.
module burst_sram
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] dq_in,
    input  logic              ts_cpu_n,
    input  logic              ts_ctl_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              we_lo_n,
    input  logic              we_hi_n,
    input  logic              oe_n,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_en
);
    bsr_ctrl_t         ctrl;
    logic              sel_next;
    logic              sel_q;
    logic [ADDR_W-1:0] a_q;
    logic              wr_q;
    logic              rd_q;
    logic [LANES-1:0]  lane_q;
    logic [WORD_W-1:0] din_q;
    logic [WORD_W-1:0] rdata_q;
    logic              rv_q;

    // Pin polarity conversion into the internal control bundle.
    always_comb begin
        ctrl.start     = !ts_cpu_n || !ts_ctl_n;
        ctrl.cpu_start = !ts_cpu_n;
        ctrl.ce        = !ce_n;
        ctrl.adv       = !adv_n;
        ctrl.we        = {!we_hi_n, !we_lo_n};
    end

    bsr_addr_ctl #(.ADDR_W(ADDR_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ctrl     (ctrl),
        .sel_next (sel_next),
        .sel_q    (sel_q),
        .a_q      (a_q)
    );

    bsr_cycle_dec dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_next (sel_next),
        .ctrl     (ctrl),
        .din      (dq_in),
        .wr_q     (wr_q),
        .rd_q     (rd_q),
        .lane_q   (lane_q),
        .din_q    (din_q)
    );

    bsr_array #(.ADDR_W(ADDR_W)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_q),
        .rd      (rd_q),
        .lane    (lane_q),
        .a       (a_q),
        .din     (din_q),
        .rdata_q (rdata_q),
        .rv_q    (rv_q)
    );

    // Bus drive: read data present, output enabled, no write in progress.
    always_comb begin
        dq_out = rdata_q;
        dq_en  = rv_q && !oe_n && !wr_q;
    end
endmodule

// File: rtl/bsr_checker.sv
// Temporal checks on the burst SRAM, bound into every burst_sram instance.
// Assumes inputs are at defined levels at every rising edge.
module bsr_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ts_cpu_n,
    input logic              ts_ctl_n,
    input logic              adv_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              dq_en,
    input logic              sel_q,
    input logic [ADDR_W-1:0] a_q,
    input logic              wr_q
);
    logic start;
    assign start = !ts_cpu_n || !ts_ctl_n;

    // R2: a selecting start loads the external address
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ce_n) |=> (sel_q && a_q == $past(addr)));

    // R3: a start with chip enable high deselects and blocks writes
    p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ce_n) |=> (!sel_q && !wr_q));

    // R4: advance steps the low bits and leaves the upper bits alone
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && sel_q && !adv_n) |=>
        (a_q[1:0] == 2'($past(a_q[1:0]) + 2'd1) &&
         a_q[ADDR_W-1:2] == $past(a_q[ADDR_W-1:2])));

    // R5: no start and no advance keeps address and selection
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv_n) |=> ($stable(a_q) && $stable(sel_q)));

    // R8: a processor start never produces a write cycle
    p_cpu_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_cpu_n |=> !wr_q);

    // R10: output enable high means no drive
    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_en);

    // R11: no drive during a write cycle
    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> !dq_en);
endmodule

bind burst_sram bsr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ts_cpu_n (ts_cpu_n),
    .ts_ctl_n (ts_ctl_n),
    .adv_n    (adv_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .dq_en    (dq_en),
    .sel_q    (sel_q),
    .a_q      (a_q),
    .wr_q     (wr_q)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [17:0]   dq_in = '0;
    logic          ts_cpu_n = 1'b1, ts_ctl_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1;
    logic          we_lo_n = 1'b1, we_hi_n = 1'b1, oe_n = 1'b1;
    logic [17:0]   dq_out;
    logic          dq_en;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag   = "R9";
    bit    done  = 1'b0;

    // Reference model state.
    logic          m_sel, m_wr, m_rd, m_rv;
    logic [AW-1:0] m_a;
    logic [1:0]    m_lane;
    logic [17:0]   m_din, m_rdata;
    logic [17:0]   m_mem [DEPTH];

    always #5 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in),
        .ts_cpu_n(ts_cpu_n), .ts_ctl_n(ts_ctl_n), .adv_n(adv_n), .ce_n(ce_n),
        .we_lo_n(we_lo_n), .we_hi_n(we_hi_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_en(dq_en)
    );

    function automatic logic [17:0] pattern(input logic [AW-1:0] a);
        return 18'((32'(a) * 32'd2731) ^ 32'h2D5A7);
    endfunction

    task automatic check(input string t, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // Model update for one rising edge, from the pins applied before it.
    task automatic model_edge();
        logic nrv;
        logic [17:0] nrd;
        nrv = m_rd;
        nrd = m_mem[m_a];
        if (m_wr) begin
            if (m_lane[0]) m_mem[m_a][8:0]  = m_din[8:0];
            if (m_lane[1]) m_mem[m_a][17:9] = m_din[17:9];
        end
        m_rv    = nrv;
        m_rdata = nrd;
        if (!ts_cpu_n || !ts_ctl_n) begin
            m_sel = !ce_n;
            if (!ce_n) m_a = addr;
        end else if (m_sel && !adv_n) begin
            m_a[1:0] = m_a[1:0] + 2'd1;
        end
        m_wr   = m_sel && (!we_lo_n || !we_hi_n) && ts_cpu_n;
        m_rd   = m_sel && !m_wr;
        m_lane = {!we_hi_n, !we_lo_n};
        m_din  = dq_in;
    endtask

    task automatic check_bus();
        logic e;
        e = m_rv && !oe_n && !m_wr;
        check(tag, 18'(dq_en), 18'(e));
        if (e) check(tag, dq_out, m_rdata);
    endtask

    // One clock cycle: apply pins at the falling edge, update the model at the
    // rising edge, compare at the next falling edge.
    task automatic cyc(input logic cpu, input logic ctl, input logic adv, input logic ce,
                       input logic wlo, input logic whi, input logic oe,
                       input logic [AW-1:0] a, input logic [17:0] d);
        ts_cpu_n = cpu; ts_ctl_n = ctl; adv_n = adv; ce_n = ce;
        we_lo_n = wlo; we_hi_n = whi; oe_n = oe; addr = a; dq_in = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_bus();
    endtask

    task automatic idle(input logic oe);
        cyc(1, 1, 1, 0, 1, 1, oe, '0, 18'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_sel = 0; m_wr = 0; m_rd = 0; m_rv = 0; m_a = '0;
        m_lane = '0; m_din = '0; m_rdata = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 18'h0;
        repeat (3) @(negedge clk);
        // R1: reset state, bus not driven
        check("R1", 18'(dq_en), 18'h0);
        rst_n = 1'b1;
        tag = "R1";
        idle(0);

        // Preload every word through controller-started full-word writes.
        tag = "R7";
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 0, 0, 0, 1, AW'(i), pattern(AW'(i)));

        // R2 / R4 / R9: processor-started read burst wrapping 1,2,3,0
        tag = "R4";
        cyc(0, 1, 1, 0, 1, 1, 0, AW'(10'h105), 18'h0);
        cyc(1, 1, 0, 1, 1, 1, 0, '0, 18'h0);
        cyc(1, 1, 0, 1, 1, 1, 0, '0, 18'h0);
        cyc(1, 1, 0, 1, 1, 1, 0, '0, 18'h0);
        idle(0);
        check("R4", 18'(dq_en), 18'h1);
        check("R4", dq_out, pattern(AW'(10'h104)));

        // R2 with controller strobe, R9 latency
        tag = "R2";
        cyc(1, 0, 1, 0, 1, 1, 0, AW'(10'h3F2), 18'h0);
        idle(0);
        check("R9", dq_out, pattern(AW'(10'h3F2)));

        // R5: no advance holds the address
        tag = "R5";
        cyc(1, 1, 1, 1, 1, 1, 0, AW'(10'h011), 18'h0);
        cyc(1, 1, 1, 1, 1, 1, 0, AW'(10'h022), 18'h0);
        check("R5", dq_out, pattern(AW'(10'h3F2)));

        // R6: start and advance together, start wins
        tag = "R6";
        cyc(1, 0, 0, 0, 1, 1, 0, AW'(10'h208), 18'h0);
        idle(0);
        check("R6", dq_out, pattern(AW'(10'h208)));

        // R3: deselecting start, then ce low without a start is ignored
        tag = "R3";
        cyc(0, 1, 1, 1, 1, 1, 0, AW'(10'h050), 18'h0);
        cyc(1, 1, 0, 0, 0, 0, 0, AW'(10'h051), 18'h3FFFF);
        cyc(1, 1, 0, 0, 1, 1, 0, '0, 18'h0);
        check("R3", 18'(dq_en), 18'h0);
        cyc(0, 1, 1, 0, 1, 1, 0, AW'(10'h208), 18'h0);
        idle(0);
        check("R3", dq_out, pattern(AW'(10'h208)));

        // R7: lower-lane only then upper-lane only writes
        tag = "R7";
        cyc(1, 0, 1, 0, 0, 1, 1, AW'(10'h0C0), 18'h2AAAA);
        cyc(1, 0, 1, 0, 1, 0, 1, AW'(10'h0C1), 18'h15555);
        cyc(0, 1, 1, 0, 1, 1, 0, AW'(10'h0C0), 18'h0);
        cyc(1, 1, 0, 0, 1, 1, 0, '0, 18'h0);
        check("R7", dq_out, {pattern(AW'(10'h0C0))[17:9], 9'h0AA});
        idle(0);
        check("R7", dq_out, {9'h0AA, pattern(AW'(10'h0C1))[8:0]});

        // R8: processor start with write enables low reads, memory unchanged
        tag = "R8";
        cyc(0, 1, 1, 0, 0, 0, 0, AW'(10'h300), 18'h00000);
        idle(0);
        check("R8", dq_out, pattern(AW'(10'h300)));

        // R11: write with output enable low, bus stays off
        tag = "R11";
        cyc(1, 0, 1, 0, 0, 0, 0, AW'(10'h301), 18'h12345);
        check("R11", 18'(dq_en), 18'h0);
        cyc(0, 1, 1, 0, 1, 1, 0, AW'(10'h301), 18'h0);
        idle(0);
        check("R11", dq_out, 18'h12345);

        // R10: output enable acts between clock edges
        tag = "R10";
        #1 oe_n = 1'b1;
        #1 check("R10", 18'(dq_en), 18'h0);
        #1 oe_n = 1'b0;
        #1 check("R10", 18'(dq_en), 18'h1);

        // Random traffic against the model.
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 8);
            cyc(r != 0, r != 1, 1'($urandom), ($urandom % 6) == 0,
                1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                AW'($urandom), 18'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule